// File: doc/BRIEF.md
# Shared-Region Bus Contention Arbiter

This block decides, cycle by cycle, whether a processor access has to wait for a video fetcher. Only one address window is contended: the RAM that the processor and the video fetcher both use. The window's base and size are parameters. The block stalls the processor only when it addresses that window while the video fetcher is reading it. Code fetches from ROM, and accesses to any other RAM, go ahead at full speed even during video reads.

The isolation buffers sit between the processor bus and the shared RAM rather than around the processor. While video owns the shared RAM, the processor keeps its own bus for every other device. The block drives two enables for these buffers, one for the processor side and one for the video side, and a grant back to the video fetcher. Video always wins a contended cycle.

A saturating counter totals the stalled cycles, so a bench can measure how much the region-limited stall saves. All outputs are registered and reflect the inputs sampled at the previous rising clock edge.

Top module: `region_contention_arbiter`

## Requirements
- R1: An address is in the shared window when `(cpu_addr & ~(REGION_SIZE-1)) == REGION_BASE`. The window is power-of-two sized and aligned. With the defaults (16-bit address, base 0, size 16384) the window is 0x0000 to 0x3FFF, and 0x4000 is outside it.
- R2: `cpu_stall` is 1 in the cycle after an edge at which `cpu_req` was 1, `cpu_addr` was in the window and `vid_busy` was 1.
- R3: A processor access outside the window, whether to ROM (for example 0xC000 and up) or to other RAM, never raises `cpu_stall`, whatever the value of `vid_busy`.
- R4: Video has priority. `vid_grant` equals the value `vid_busy` had at the previous edge, whatever the processor is doing.
- R5: `ram_vid_en` equals the previous `vid_busy`. `ram_cpu_en` is 1 after an in-window request made while `vid_busy` was 0. The two enables are never 1 together.
- R6: Once `vid_busy` drops, or the in-window request ends, `cpu_stall` falls at the next edge.
- R7: `stall_count` rises by one for every cycle in which `cpu_stall` is 1. It holds its value at all-ones instead of wrapping.
- R8: While the synchronous active-high `rst` is sampled 1, all outputs are 0 and `stall_count` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_req | input | 1 | Processor access strobe |
| vid_busy | input | 1 | Video fetcher is reading the shared RAM |
| cpu_stall | output | 1 | Hold the processor in its current cycle |
| ram_cpu_en | output | 1 | Connect the processor bus to the shared RAM |
| ram_vid_en | output | 1 | Connect the video fetcher to the shared RAM |
| vid_grant | output | 1 | Video access granted |
| stall_count | output | CNT_W | Saturating total of stalled cycles |

## Verification
The assertions take for granted that `cpu_addr`, `cpu_req` and `vid_busy` are stable around the rising edge. They also assume the window parameters are power-of-two aligned. Their `$past` terms only mean something once one full cycle out of reset has passed. The bench keeps within these limits: it changes inputs only at the falling edge and keeps the default aligned window. It runs the counter with a 4-bit width, so saturation is reached within a few dozen stalled cycles. Directed patterns cover ROM fetches, other RAM, both sides of the window edge and video release. A pseudo-random tail follows, with its addresses spread across all four quarters of the map.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // Registered decision for one cycle
  typedef struct packed {
    logic stall;
    logic cpu_en;
    logic vid_en;
    logic grant;
  } arb_out_t;
endpackage

// File: rtl/shared_region_decode.sv
module shared_region_decode #(
  parameter int          ADDR_W      = 16,
  parameter int unsigned REGION_BASE = 0,
  parameter int unsigned REGION_SIZE = 16384
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_req,
  output logic              in_region,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] OFFS_MASK = ADDR_W'(REGION_SIZE - 1);
  localparam logic [ADDR_W-1:0] BASE_VAL  = ADDR_W'(REGION_BASE);

  always_comb begin
    in_region = ((cpu_addr & ~OFFS_MASK) == BASE_VAL);
    hit       = cpu_req && in_region;
  end
endmodule

// File: rtl/contention_grant.sv
module contention_grant
  import arb_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     hit,
  input  logic     vid_busy,
  output arb_out_t q
);
  arb_out_t d;

  always_comb begin
    d.grant  = vid_busy;
    d.vid_en = vid_busy;
    d.stall  = hit && vid_busy;
    d.cpu_en = hit && !vid_busy;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  AST_ENABLES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(q.cpu_en && q.vid_en)); // R5
endmodule

// File: rtl/stall_counter.sv
module stall_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (inc && cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1))); // R7
  AST_COUNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(cnt) == CNT_MAX |-> cnt == CNT_MAX); // R7
endmodule

// File: rtl/region_contention_arbiter.sv
module region_contention_arbiter
  import arb_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int unsigned REGION_BASE = 0,
  parameter int unsigned REGION_SIZE = 16384,
  parameter int          CNT_W       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_req,
  input  logic              vid_busy,
  output logic              cpu_stall,
  output logic              ram_cpu_en,
  output logic              ram_vid_en,
  output logic              vid_grant,
  output logic [CNT_W-1:0]  stall_count
);
  logic     in_region;
  logic     hit;
  arb_out_t q;

  shared_region_decode #(
    .ADDR_W(ADDR_W), .REGION_BASE(REGION_BASE), .REGION_SIZE(REGION_SIZE)
  ) u_decode (
    .cpu_addr(cpu_addr), .cpu_req(cpu_req), .in_region(in_region), .hit(hit)
  );

  contention_grant u_grant (
    .clk(clk), .rst(rst), .hit(hit), .vid_busy(vid_busy), .q(q)
  );

  // Counts each cycle that the registered stall is about to show
  stall_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .inc(hit && vid_busy), .cnt(stall_count)
  );

  assign cpu_stall  = q.stall;
  assign ram_cpu_en = q.cpu_en;
  assign ram_vid_en = q.vid_en;
  assign vid_grant  = q.grant;

  AST_STALL_NEEDS_VIDEO: assert property (@(posedge clk) disable iff (rst)
    cpu_stall |-> $past(vid_busy) && $past(cpu_req)); // R2
  AST_NO_STALL_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    !$past(in_region) |-> !cpu_stall); // R3
  AST_VIDEO_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(vid_busy) |-> vid_grant && !ram_cpu_en); // R4
  AST_STALL_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(vid_busy) |=> !cpu_stall); // R6
endmodule

// File: tb/region_contention_arbiter_tb.sv
module region_contention_arbiter_tb;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 4;

  logic              clk = 0;
  logic              rst = 1;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic              cpu_req = 0;
  logic              vid_busy = 0;
  logic              cpu_stall, ram_cpu_en, ram_vid_en, vid_grant;
  logic [CNT_W-1:0]  stall_count;

  region_contention_arbiter #(.ADDR_W(ADDR_W), .REGION_BASE(0),
    .REGION_SIZE(16384), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_req(cpu_req),
    .vid_busy(vid_busy), .cpu_stall(cpu_stall), .ram_cpu_en(ram_cpu_en),
    .ram_vid_en(ram_vid_en), .vid_grant(vid_grant), .stall_count(stall_count));

  always #5 clk = ~clk;

  // Reference model: behavioural, from the requirements
  int  checks = 0, fails = 0, cycles = 0;
  bit  e_stall, e_cen, e_ven, e_grant, e_prev_stall, e_in_rst, e_outside;
  int  e_count = 0;
  bit  running = 1;

  always @(posedge clk) begin
    int a;
    bit inwin;
    a = int'(cpu_addr);
    inwin = (a >= 0) && (a < 16384);       // R1 window
    e_prev_stall = e_stall;
    if (rst) begin
      {e_stall, e_cen, e_ven, e_grant} = '0; e_count = 0; e_in_rst = 1;
      e_outside = 0;
    end else begin
      e_in_rst  = 0;
      e_outside = cpu_req && !inwin;
      e_stall   = cpu_req && inwin && vid_busy;
      e_cen     = cpu_req && inwin && !vid_busy;
      e_ven     = vid_busy;
      e_grant   = vid_busy;
      if (e_stall && e_count < 15) e_count++;
    end
  end

  task automatic chk(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) if (running) begin
    string sreq;
    cycles++;
    if (e_in_rst) sreq = "R8";
    else if (e_outside) sreq = "R3";
    else if (e_prev_stall && !e_stall) sreq = "R6";
    else sreq = "R2";
    chk(cpu_stall, e_stall, sreq);
    chk(ram_cpu_en, e_cen, e_in_rst ? "R8" : "R5");
    chk(ram_vid_en, e_ven, e_in_rst ? "R8" : "R5");
    chk(vid_grant, e_grant, e_in_rst ? "R8" : "R4");
    checks++;
    if (int'(stall_count) != e_count) begin
      fails++;
      $display("FAIL %s: stall_count actual %0d expected %0d", e_in_rst ? "R8" : "R7",
               stall_count, e_count);
    end
  end

  task automatic drive(input int addr, input bit req, input bit busy, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cpu_addr = ADDR_W'(addr); cpu_req = req; vid_busy = busy;
    end
  endtask

  initial begin
    // R8: reset with busy inputs still gives zeros
    drive(16'h0010, 1, 1, 3);
    @(negedge clk); rst = 0;
    drive(16'hC000, 1, 1, 4);   // R3: ROM fetch during video
    drive(16'h8000, 1, 1, 3);   // R3: other RAM during video
    drive(16'h1000, 1, 0, 3);   // R5: shared, no video
    drive(16'h2000, 1, 1, 5);   // R2: contended
    drive(16'h2000, 1, 0, 2);   // R6: video drops
    drive(16'h3FFF, 1, 1, 2);   // R1: last in-window address
    drive(16'h4000, 1, 1, 2);   // R1: first outside
    drive(16'h0000, 0, 1, 3);   // R4: video alone, no request
    drive(16'h0100, 1, 1, 20);  // R7: saturate at 15
    drive(16'h0100, 1, 0, 2);
    @(negedge clk); rst = 1;    // R8: reset clears the count
    drive(16'h0100, 1, 1, 2);
    @(negedge clk); rst = 0;
    for (int k = 0; k < 400; k++)
      drive(int'($urandom_range(0, 65535)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), 1);
    drive(0, 0, 0, 3);
    running = 0;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    running = 0;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule